// File: doc/BRIEF.md
# Pending MSI Vector Scanner

This block services one termination group of a message-signalled interrupt controller after that group's interrupt line fires. Given a group number and a start strobe, it reads the group's summary register to find out which index registers hold pending messages. It takes the lowest flagged index and reads that index register; the read clears the register. It then walks the returned bits from the lowest bit upward and emits one global vector number per set bit.

Once every bit in the local copy of the summary has been handled, the scanner reads the summary register again. It finishes only when that fresh read comes back empty. Register reads use a request/acknowledge master port whose latency can vary. Vector numbers leave on a valid/ready stream. While `vec_valid_o` is high and `vec_ready_i` is low, the number is held unchanged. A vector counts as taken on a rising clock edge where both are high, and the next vector appears no earlier than the following cycle.

Top module: `msi_vector_scanner`

## Requirements
- R1: After reset the scanner is idle: `busy_o`, `done_o`, `rd_req_o` and `vec_valid_o` are all low.
- R2: A start strobe seen while idle latches `group_i`, raises `busy_o` on the next cycle, and begins with a summary read (`rd_summary_o` = 1) of that group.
- R3: `rd_req_o` and the read address (`rd_summary_o`, `rd_group_o`, `rd_index_o`) stay constant until a cycle with `rd_ack_i` high. `rd_data_i` is taken in that cycle. Any number of wait cycles is allowed.
- R4: Each index read (`rd_summary_o` = 0) targets the lowest set bit of the local summary copy. Each flagged index is read once per summary snapshot.
- R5: For each set bit b of an index value read from index register i of group g, a vector numbered (i*16 + b)*16 + g is emitted. Within one index value, bits go out in increasing order of b.
- R6: While `vec_valid_o` is high and `vec_ready_i` is low, `vec_valid_o` stays high and `vec_num_o` keeps its value.
- R7: An index read that returns zero emits nothing. The scanner then moves on to the next flagged index.
- R8: A new summary read is issued only after the local summary copy is empty and all of its vectors have been taken. A non-zero result continues the scan.
- R9: A summary read that returns zero produces a single-cycle `done_o` pulse in the next cycle, with `busy_o` already low. A new start is accepted after that.
- R10: A start strobe that arrives while `busy_o` is high has no effect on the group being scanned.
- R11: Only bits 7:0 of a summary read are used. Set bits above bit 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a group scan |
| group_i | input | 4 | Group to scan, sampled with start |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when a scan ends |
| rd_req_o | output | 1 | Register read request |
| rd_summary_o | output | 1 | 1 = summary register, 0 = index register |
| rd_group_o | output | 4 | Group of the register read |
| rd_index_o | output | 3 | Index register number (index reads) |
| rd_ack_i | input | 1 | Read acknowledge, qualifies rd_data_i |
| rd_data_i | input | 32 | Read data |
| vec_valid_o | output | 1 | Vector number valid |
| vec_ready_i | input | 1 | Downstream accepts vector |
| vec_num_o | output | 11 | Global vector number |

## Verification
The hardest case to reach from the ports is a message that lands in a group after its summary snapshot has been taken but before the scan ends. Only the final summary re-read catches such a message. The bench writes new pending bits into its register model while a scan is busy, and it slows the scan with random back-pressure and read latency so that the write falls inside the window. It also presents a summary bit whose index register reads back as zero, which exercises the empty-index path. A start for another group is issued while the scanner is busy, and that group's pending bit is later shown to be still in place.

// File: rtl/msi_scan_pkg.sv
package msi_scan_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_SUM  = 2'd1,
    SCAN_IDX  = 2'd2,
    SCAN_EMIT = 2'd3
  } scan_state_e;
endpackage

// File: rtl/msi_lowest_set.sv
module msi_lowest_set #(
  parameter int W = 8
) (
  input  logic [W-1:0]         vec_i,
  output logic [$clog2(W)-1:0] pos_o,
  output logic                 any_o
);
  localparam int PW = $clog2(W);

  always_comb begin
    pos_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) pos_o = PW'(k);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/msi_vec_compose.sv
module msi_vec_compose #(
  parameter int GRP_W = 4,
  parameter int IDX_W = 3,
  parameter int BIT_W = 4
) (
  input  logic [GRP_W-1:0]             grp_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [BIT_W-1:0]             bit_i,
  output logic [GRP_W+IDX_W+BIT_W-1:0] vec_o
);
  // Power-of-two field sizes: (idx*BITS + bit)*GROUPS + grp is a concatenation
  assign vec_o = {idx_i, bit_i, grp_i};
endmodule

// File: rtl/msi_vector_scanner.sv
module msi_vector_scanner #(
  parameter int NUM_GROUPS    = 16,
  parameter int IDX_PER_GROUP = 8,
  parameter int VEC_PER_IDX   = 16,
  parameter int RD_DATA_W     = 32,
  localparam int GRP_W = $clog2(NUM_GROUPS),
  localparam int IDX_W = $clog2(IDX_PER_GROUP),
  localparam int BIT_W = $clog2(VEC_PER_IDX),
  localparam int VEC_W = GRP_W + IDX_W + BIT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [GRP_W-1:0]     group_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 rd_req_o,
  output logic                 rd_summary_o,
  output logic [GRP_W-1:0]     rd_group_o,
  output logic [IDX_W-1:0]     rd_index_o,
  input  logic                 rd_ack_i,
  input  logic [RD_DATA_W-1:0] rd_data_i,
  output logic                 vec_valid_o,
  input  logic                 vec_ready_i,
  output logic [VEC_W-1:0]     vec_num_o
);
  import msi_scan_pkg::*;

  scan_state_e              state_q;
  logic [GRP_W-1:0]         grp_q;
  logic [IDX_PER_GROUP-1:0] sum_q;
  logic [VEC_PER_IDX-1:0]   bits_q;
  logic                     done_q;

  logic [IDX_W-1:0]         cur_idx;
  logic [BIT_W-1:0]         cur_bit;
  logic                     sum_any, bits_any;
  logic [IDX_PER_GROUP-1:0] sum_after;
  logic [VEC_PER_IDX-1:0]   bits_after;
  logic [IDX_PER_GROUP-1:0] rd_sum_val;
  logic [VEC_PER_IDX-1:0]   rd_idx_val;

  msi_lowest_set #(.W(IDX_PER_GROUP)) u_idx_pick (
    .vec_i(sum_q), .pos_o(cur_idx), .any_o(sum_any)
  );

  msi_lowest_set #(.W(VEC_PER_IDX)) u_bit_pick (
    .vec_i(bits_q), .pos_o(cur_bit), .any_o(bits_any)
  );

  msi_vec_compose #(.GRP_W(GRP_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_compose (
    .grp_i(grp_q), .idx_i(cur_idx), .bit_i(cur_bit), .vec_o(vec_num_o)
  );

  assign sum_after  = sum_q & ~(IDX_PER_GROUP'(1) << cur_idx);
  assign bits_after = bits_q & ~(VEC_PER_IDX'(1) << cur_bit);
  assign rd_sum_val = rd_data_i[IDX_PER_GROUP-1:0];
  assign rd_idx_val = rd_data_i[VEC_PER_IDX-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      grp_q   <= '0;
      sum_q   <= '0;
      bits_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SCAN_IDLE: begin
          if (start_i) begin
            grp_q   <= group_i;
            sum_q   <= '0;
            state_q <= SCAN_SUM;
          end
        end
        SCAN_SUM: begin
          if (rd_ack_i) begin
            sum_q <= rd_sum_val;
            if (rd_sum_val == '0) begin
              done_q  <= 1'b1;
              state_q <= SCAN_IDLE;
            end else begin
              state_q <= SCAN_IDX;
            end
          end
        end
        SCAN_IDX: begin
          if (rd_ack_i) begin
            if (rd_idx_val == '0) begin
              sum_q   <= sum_after;
              state_q <= (sum_after == '0) ? SCAN_SUM : SCAN_IDX;
            end else begin
              bits_q  <= rd_idx_val;
              state_q <= SCAN_EMIT;
            end
          end
        end
        SCAN_EMIT: begin
          if (vec_ready_i) begin
            bits_q <= bits_after;
            if (bits_after == '0) begin
              sum_q   <= sum_after;
              state_q <= (sum_after == '0) ? SCAN_SUM : SCAN_IDX;
            end
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != SCAN_IDLE);
  assign done_o       = done_q;
  assign rd_req_o     = (state_q == SCAN_SUM) || (state_q == SCAN_IDX);
  assign rd_summary_o = (state_q == SCAN_SUM);
  assign rd_group_o   = grp_q;
  assign rd_index_o   = cur_idx;
  assign vec_valid_o  = (state_q == SCAN_EMIT) && bits_any;

  logic unused_any;
  assign unused_any = sum_any;
endmodule

// File: rtl/msi_vector_scanner_chk.sv
module msi_vector_scanner_chk #(
  parameter int GRP_W = 4,
  parameter int IDX_W = 3,
  parameter int VEC_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             rd_req_o,
  input logic             rd_summary_o,
  input logic [GRP_W-1:0] rd_group_o,
  input logic [IDX_W-1:0] rd_index_o,
  input logic             rd_ack_i,
  input logic             vec_valid_o,
  input logic             vec_ready_i,
  input logic [VEC_W-1:0] vec_num_o
);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_summary_o)
                              && $stable(rd_group_o) && $stable(rd_index_o));

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o && !vec_ready_i |=> vec_valid_o && $stable(vec_num_o));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !rd_req_o && !vec_valid_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  group_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(rd_group_o));

  // R5
  vec_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> vec_num_o[GRP_W-1:0] == rd_group_o && !rd_req_o);

  // R2
  busy_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o || vec_valid_o) |-> busy_o);
endmodule

bind msi_vector_scanner msi_vector_scanner_chk #(
  .GRP_W(GRP_W), .IDX_W(IDX_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .rd_req_o(rd_req_o), .rd_summary_o(rd_summary_o), .rd_group_o(rd_group_o),
  .rd_index_o(rd_index_o), .rd_ack_i(rd_ack_i), .vec_valid_o(vec_valid_o),
  .vec_ready_i(vec_ready_i), .vec_num_o(vec_num_o)
);

// File: tb/msi_vector_scanner_bench.sv
module msi_vector_scanner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  group_i = '0;
  logic        busy_o, done_o, rd_req_o, rd_summary_o;
  logic [3:0]  rd_group_o;
  logic [2:0]  rd_index_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        vec_valid_o;
  logic        vec_ready_i = 1'b1;
  logic [10:0] vec_num_o;

  always #4 clk = ~clk;

  msi_vector_scanner u_msi_vector_scanner (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .group_i(group_i),
    .busy_o(busy_o), .done_o(done_o), .rd_req_o(rd_req_o),
    .rd_summary_o(rd_summary_o), .rd_group_o(rd_group_o),
    .rd_index_o(rd_index_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .vec_valid_o(vec_valid_o), .vec_ready_i(vec_ready_i), .vec_num_o(vec_num_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 0;

  logic [15:0] ir [16][8];
  logic [7:0]  ghost [16];

  int         exp_q[$];
  bit         m_busy = 0;
  logic [3:0] m_grp = '0;
  logic [7:0] m_sum = '0;
  bit         done_due = 0;
  bit         ready_rand = 0;
  int         wcnt = 0;
  int         lat = 0;
  logic [31:0] lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int lowest8(input logic [7:0] v);
    int p = -1;
    for (int k = 7; k >= 0; k--) if (v[k]) p = k;
    return p;
  endfunction

  function automatic logic [7:0] summary_of(input int g);
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = (ir[g][i] != 0) | ghost[g][i];
    return s;
  endfunction

  // behavioural reference, compared every clock at the falling edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      // R9 done pulse timing
      chk(done_o == done_due, "R9 done_o", done_o, done_due);
      done_due = 0;
      // R2 busy tracking
      chk(busy_o == m_busy, "R2 busy_o", busy_o, m_busy);
      // R5/R6 vector stream
      chk(vec_valid_o == (exp_q.size() != 0), "R6 vec_valid_o", vec_valid_o, exp_q.size() != 0);
      if (vec_valid_o && exp_q.size() != 0)
        chk(vec_num_o == exp_q[0], "R5 vec_num_o", vec_num_o, exp_q[0]);
      vec_ready_i = ready_rand ? lcg[20] : 1'b1;
      if (vec_valid_o && vec_ready_i && exp_q.size() != 0) void'(exp_q.pop_front());
      // read port
      if (rd_ack_i) begin
        rd_ack_i = 0;
        wcnt = 0;
      end else if (rd_req_o) begin
        chk(rd_group_o == m_grp, "R10 rd_group_o", rd_group_o, m_grp);
        if (wcnt < lat) wcnt++;
        else begin
          rd_ack_i = 1;
          lat = int'(lcg[27:26]);
          if (rd_summary_o) begin
            logic [7:0] s;
            chk(m_sum == 0 && exp_q.size() == 0, "R8 summary re-read", m_sum, 0);
            s = summary_of(rd_group_o);
            rd_data_i = {24'h5A_C3FF, s};   // R11: upper bits set, ignored
            m_sum = s;
            if (s == 0) begin
              done_due = 1;
              m_busy = 0;
            end
          end else begin
            int e;
            e = lowest8(m_sum);
            chk(e >= 0 && rd_index_o == e[2:0], "R4 rd_index_o", rd_index_o, e);
            rd_data_i = {16'hBEEF, ir[rd_group_o][rd_index_o]};
            for (int b = 0; b < 16; b++)
              if (ir[rd_group_o][rd_index_o][b])
                exp_q.push_back((int'(rd_index_o) * 16 + b) * 16 + int'(rd_group_o));
            ir[rd_group_o][rd_index_o] = '0;
            ghost[rd_group_o][rd_index_o] = 1'b0;
            if (e >= 0) m_sum[e] = 1'b0;
          end
        end
      end
      if (start_i && !m_busy) begin
        m_busy = 1;
        m_grp = group_i;
        m_sum = '0;
      end
    end
  end

  task automatic pulse_start(input logic [3:0] g);
    @(posedge clk); #2;
    start_i = 1; group_i = g;
    @(posedge clk); #2;
    start_i = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((m_busy || busy_o) && n < 20000) begin
      @(posedge clk); #2;
      n++;
    end
    repeat (2) @(posedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      chk(0, "watchdog expired", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 16; g++) begin
      ghost[g] = '0;
      for (int i = 0; i < 8; i++) ir[g][i] = '0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    // R1 reset state
    chk(!busy_o && !done_o && !rd_req_o && !vec_valid_o, "R1 idle after reset",
        {busy_o, done_o, rd_req_o, vec_valid_o}, 0);

    // single vector: idx 0 bit 0 group 3 -> 3
    ir[3][0] = 16'h0001;
    pulse_start(4'd3);
    wait_idle();

    // several indices, bits 0 and 15, back-pressure
    ready_rand = 1;
    ir[5][1] = 16'h8001; ir[5][4] = 16'h0120; ir[5][7] = 16'h8000;
    pulse_start(4'd5);
    wait_idle();

    // late arrivals during a scan, plus a start while busy (R8, R10)
    ir[11][3] = 16'h0001;
    ir[2][2] = 16'h00F0;
    pulse_start(4'd2);
    repeat (3) @(posedge clk); #2;
    ir[2][0] = 16'h0002; ir[2][6] = 16'h0400;
    pulse_start(4'd11);
    wait_idle();
    @(negedge clk);
    chk(ir[11][3] == 16'h0001, "R10 other group untouched", ir[11][3], 1);

    // stale summary bit whose index reads zero (R7)
    ghost[9] = 8'h10; ir[9][6] = 16'h0004;
    pulse_start(4'd9);
    wait_idle();

    // empty group: immediate done
    pulse_start(4'd0);
    wait_idle();

    // full index registers, highest vectors
    ir[15][7] = 16'hFFFF; ir[15][0] = 16'hFFFF;
    pulse_start(4'd15);
    wait_idle();

    // drain the group left pending
    ready_rand = 0;
    pulse_start(4'd11);
    wait_idle();
    @(negedge clk);
    chk(ir[11][3] == 16'h0000, "R4 group read clears", ir[11][3], 0);
    chk(exp_q.size() == 0, "R5 all vectors delivered", exp_q.size(), 0);

    fin = 1;
    report();
    $finish;
  end
endmodule